// File: doc/BRIEF.md
# DDR Read Request Sequencer

This block sits between a bus slave port and a DDR memory controller and runs the read side of the memory path. A read starts when chip-select and read-request are both high and the controller's address queue is not almost full. For a single read it sends one command, waits for the controller's data-valid strobe, and then acknowledges the read to the bus over two cycles with the returned word.

The acknowledge is shifted by one cycle when the slower bus clock is high at the moment data returns. This keeps the two-cycle acknowledge lined up with that clock.

For a burst, the block sends one command per 16-byte unit, starting at the 16-byte-aligned base address. It then pushes every returned beat into a read FIFO. Each 16-byte unit comes back as two 64-bit beats, handled by a pair of alternating queue states. Once the whole burst has arrived, the block waits until a separate unload machine reports that the FIFO has been drained to the bus. That unload machine and the controller itself are not part of this block.

Top module: `ddr_rd_seq`

## Requirements
- R1: Reset is synchronous and active high. While it is held, and on the first cycle after it is released, `cmd_send`, `ack_send` and `fifo_push` are 0 and `burst_cnt` is 0.
- R2: `cmd_send` is high only when the sequencer is idle, `cs`=1, `rd_req`=1 and `af_full`=0. While `af_full`=1, no command is sent and the request is held off.
- R3: A single read (`burst`=0) sends exactly one command, with `cmd_addr` equal to `addr`. From the next cycle the block waits for `rd_valid`.
- R4: A burst (`burst`=1) sends `burst_len`/16 commands. Command k (counting from 0) carries address (`addr` with bits 3:0 cleared) + 16·k. `burst_cnt` shows the number of commands sent so far and reads 0 while idle. A cycle with `af_full`=1 skips a command without losing it. Waiting for data begins in the cycle after the last command.
- R5: On a single read, if `rd_valid` is seen with `bus_phase`=0, `ack_send` is high on the next two cycles.
- R6: On a single read, if `rd_valid` is seen with `bus_phase`=1, there is one extra cycle with `ack_send` low, and then two cycles with it high.
- R7: The acknowledge always lasts exactly two cycles, and `rd_out` carries the `rd_data` captured with `rd_valid`. A new read may start in the cycle after the acknowledge ends.
- R8: During a burst, each `rd_valid` beat raises `fifo_push` in that same cycle, with `fifo_data` equal to `rd_data`, until 2·`burst_len`/16 beats have been taken.
- R9: After the last burst beat, further `rd_valid` pulses are ignored. The block stays busy until `drain_done`=1, then returns to idle with `burst_cnt` cleared.
- R10: `rd_valid` while idle or while acknowledging pushes nothing and produces no acknowledge. No command is sent while a read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast memory-side clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Memory selected by the bus |
| rd_req | input | 1 | Bus read request |
| burst | input | 1 | Request is a burst |
| burst_len | input | LW | Burst length in bytes (multiple of 16, at most 128) |
| addr | input | AW | Bus read address |
| af_full | input | 1 | Controller address queue almost full |
| bus_phase | input | 1 | Current level of the bus clock |
| rd_valid | input | 1 | Controller read data valid |
| rd_data | input | DW | Controller read data |
| drain_done | input | 1 | Unload machine has delivered the whole burst |
| cmd_send | output | 1 | Send a read command to the controller |
| cmd_addr | output | AW | Address for the command |
| ack_send | output | 1 | Acknowledge a single read on the bus |
| burst_cnt | output | CW | Burst commands sent so far |
| rd_out | output | DW | Single-read data for the bus |
| fifo_push | output | 1 | Write a beat into the read FIFO |
| fifo_data | output | DW | Beat written into the read FIFO |

## Verification
Single reads are run with the data strobe landing on each bus-clock phase. This separates the direct path to the acknowledge from the path with the added alignment cycle. One single read is held off by an almost-full queue, which shows that the stall only delays the command and does not drop it.

Bursts of one, four and eight units are run with gaps between data beats and a one-cycle queue stall during address issue. These patterns separate correct address stepping and beat counting from off-by-one endings. A stray strobe after the final beat, a late drain signal, and strobes while idle show that data arriving outside the expected window is ignored.

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq #(
  parameter int AW   = 32,
  parameter int DW   = 64,
  parameter int LW   = 8,
  parameter int MAXB = 128,
  localparam int CW  = $clog2(MAXB / 16) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          rd_req,
  input  logic          burst,
  input  logic [LW-1:0] burst_len,
  input  logic [AW-1:0] addr,
  input  logic          af_full,
  input  logic          bus_phase,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic          drain_done,
  output logic          cmd_send,
  output logic [AW-1:0] cmd_addr,
  output logic          ack_send,
  output logic [CW-1:0] burst_cnt,
  output logic [DW-1:0] rd_out,
  output logic          fifo_push,
  output logic [DW-1:0] fifo_data
);
  localparam int SH   = 4;
  localparam int BW   = CW + 1;
  localparam int MAXU = MAXB / 16;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_ALIGN, S_ACK1, S_ACK2, S_Q1, S_Q2, S_FIFO
  } st_t;

  st_t st, nx;
  logic bmode;
  logic [BW-1:0] got, total;

  wire          start      = (st == S_IDLE) && cs && rd_req && !af_full;
  wire [CW-1:0] units      = burst_len[SH +: CW];
  wire          last_issue = burst && (burst_cnt + 1'b1 == units);
  wire          bdone      = (got == total);

  assign cmd_send  = start && !rst;
  assign cmd_addr  = burst ? ({addr[AW-1:SH], {SH{1'b0}}} + ({{(AW-CW){1'b0}}, burst_cnt} << SH))
                           : addr;
  assign ack_send  = (st == S_ACK1) || (st == S_ACK2);
  assign fifo_push = rd_valid && ((st == S_WAIT && bmode) || st == S_Q1 || (st == S_Q2 && !bdone));
  assign fifo_data = rd_data;

  always_comb begin
    nx = st;
    case (st)
      S_IDLE:  if (start && (!burst || last_issue)) nx = S_WAIT;
      S_WAIT:  if (rd_valid) nx = bmode ? S_Q1 : (bus_phase ? S_ALIGN : S_ACK1);
      S_ALIGN: nx = S_ACK1;
      S_ACK1:  nx = S_ACK2;
      S_ACK2:  nx = S_IDLE;
      S_Q1:    if (rd_valid) nx = S_Q2;
      S_Q2:    if (bdone) nx = S_FIFO; else if (rd_valid) nx = S_Q1;
      S_FIFO:  if (drain_done) nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      bmode     <= 1'b0;
      burst_cnt <= '0;
      got       <= '0;
      total     <= '0;
      rd_out    <= '0;
    end else begin
      st <= nx;
      if (start) begin
        bmode <= burst;
        got   <= '0;
        if (burst) begin
          burst_cnt <= burst_cnt + 1'b1;
          total     <= {units, 1'b0};
        end
      end
      if (fifo_push) got <= got + 1'b1;
      if (st == S_WAIT && rd_valid && !bmode) rd_out <= rd_data;
      if (nx == S_IDLE && st != S_IDLE) burst_cnt <= '0;
    end
  end

  p_ack_pair_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_send) |=> ack_send);
  p_ack_end_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_send && $past(ack_send)) |=> !ack_send);
  p_fast_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && rd_valid && !bmode && !bus_phase) |=> $rose(ack_send));
  p_align_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && rd_valid && !bmode && bus_phase) |=> !ack_send ##1 ack_send);
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    burst_cnt <= CW'(MAXU));
  p_no_cmd_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (ack_send || fifo_push) |-> !cmd_send);
  p_push_bound_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> (got < total || (st == S_WAIT && bmode)));
  p_cmd_holdoff_r2: assert property (@(posedge clk) disable iff (rst)
    af_full |-> !cmd_send);
endmodule

// File: tb/sim_ddr_rd_seq.sv
module sim_ddr_rd_seq;
  localparam int AW = 32, DW = 64, LW = 8, CW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, cs = 0, rd_req = 0, burst = 0, af_full = 0, bus_phase = 0, rd_valid = 0, drain_done = 0;
  logic [LW-1:0] burst_len = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] rd_data = '0;
  logic cmd_send, ack_send, fifo_push;
  logic [AW-1:0] cmd_addr;
  logic [CW-1:0] burst_cnt;
  logic [DW-1:0] rd_out, fifo_data;

  ddr_rd_seq u0 (.clk, .rst, .cs, .rd_req, .burst, .burst_len, .addr, .af_full, .bus_phase,
                 .rd_valid, .rd_data, .drain_done, .cmd_send, .cmd_addr, .ack_send, .burst_cnt,
                 .rd_out, .fifo_push, .fifo_data);

  int n_chk = 0, n_bad = 0, cyc = 0, n_cmd = 0, n_push = 0;
  // behavioural model: 0 idle, 1 wait, 2 align, 3 ack, 4 queue, 5 drain
  int ph = 0, ackn = 0, issued = 0, total = 0, got = 0;
  logic mb = 0;
  logic [DW-1:0] cap = '0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<60000", cyc);
      finish_up();
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; issued = 0; mb = 0;
    end else begin
      case (ph)
        0: if (cs && rd_req && !af_full) begin
             mb = burst;
             if (burst) begin
               issued++;
               total = (burst_len / 16) * 2;
               got = 0;
               if (issued == burst_len / 16) ph = 1;
             end else ph = 1;
           end
        1: if (rd_valid) begin
             if (mb) begin got = 1; ph = 4; end
             else begin cap = rd_data; ackn = 2; ph = bus_phase ? 2 : 3; end
           end
        2: ph = 3;
        3: begin ackn--; if (ackn == 0) ph = 0; end
        4: if (got == total) ph = 5; else if (rd_valid) got++;
        5: if (drain_done) begin ph = 0; issued = 0; end
        default: ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    #1;
    if (!rst) begin
      logic e_cmd, e_push;
      e_cmd  = (ph == 0) && cs && rd_req && !af_full;
      e_push = rd_valid && ((ph == 1 && mb) || (ph == 4 && got < total));
      chk("R2 R10", "cmd_send", cmd_send, e_cmd);
      if (e_cmd)
        chk(burst ? "R4" : "R3", "cmd_addr", cmd_addr,
            burst ? ((addr & ~32'hF) + issued * 16) : addr);
      chk("R4", "burst_cnt", burst_cnt, issued);
      chk("R5 R6 R7", "ack_send", ack_send, ph == 3);
      if (ph == 3) chk("R7", "rd_out", rd_out, cap);
      chk("R8 R9 R10", "fifo_push", fifo_push, e_push);
      if (e_push) chk("R8", "fifo_data", fifo_data, rd_data);
      if (cmd_send) n_cmd++;
      if (fifo_push) n_push++;
    end
  end

  task automatic single(logic [AW-1:0] a, int stall, logic phs, int lat);
    @(negedge clk);
    cs = 1; rd_req = 1; burst = 0; addr = a; af_full = (stall > 0);
    for (int k = 0; k < stall; k++) @(negedge clk);
    af_full = 0;
    do @(negedge clk); while (ph == 0);
    cs = 0; rd_req = 0;
    repeat (lat) @(negedge clk);
    bus_phase = phs; rd_valid = 1; rd_data = {$urandom, $urandom};
    @(negedge clk);
    rd_valid = 0; bus_phase = ~phs;
    repeat (5) @(negedge clk);
  endtask

  task automatic do_burst(logic [AW-1:0] a, int len, int stall_at, int drain_delay);
    int k = 0, sent = 0, i = 0, beats;
    beats = (len / 16) * 2;
    n_cmd = 0; n_push = 0;
    @(negedge clk);
    cs = 1; rd_req = 1; burst = 1; burst_len = LW'(len); addr = a;
    af_full = (stall_at == 0);
    do begin
      @(negedge clk);
      k++;
      af_full = (k == stall_at);
    end while (ph == 0);
    af_full = 0; cs = 0; rd_req = 0; burst = 0;
    repeat (2) @(negedge clk);
    while (sent < beats) begin
      @(negedge clk);
      rd_valid = ((i % 3) != 2);
      rd_data = {$urandom, $urandom};
      if (rd_valid) sent++;
      i++;
    end
    @(negedge clk);
    rd_valid = 1; rd_data = '1;   // stray beat after the last one
    @(negedge clk);
    rd_valid = 0;
    repeat (drain_delay) @(negedge clk);
    drain_done = 1;
    @(negedge clk);
    drain_done = 0;
    repeat (2) @(negedge clk);
    chk("R4", "commands per burst", n_cmd, len / 16);
    chk("R8", "pushes per burst", n_push, beats);
    chk("R9", "idle after drain", burst_cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "cmd in reset", cmd_send, 0);
    chk("R1", "ack in reset", ack_send, 0);
    chk("R1", "push in reset", fifo_push, 0);
    chk("R1", "cnt in reset", burst_cnt, 0);
    @(negedge clk);
    rst = 0;
    #1;
    chk("R1", "cnt after reset", burst_cnt, 0);
    // R10: strobes while idle
    @(negedge clk); rd_valid = 1;
    repeat (2) @(negedge clk);
    rd_valid = 0;
    single(32'h0000_1238, 0, 1'b0, 2);   // R5
    single(32'h0000_2004, 0, 1'b1, 0);   // R6
    single(32'h0000_3010, 3, 1'b0, 1);   // R2 hold-off
    single(32'h0000_4000, 0, 1'b1, 4);   // R6 with latency
    do_burst(32'h0001_0008, 16, 99, 0);  // one unit, R9 immediate drain
    do_burst(32'h0002_0040, 64, 2, 3);   // R4 stall mid-issue
    do_burst(32'h0003_0000, 128, 5, 6);  // maximum burst
    single(32'h0000_5678, 0, 1'b0, 0);   // R7 after bursts
    finish_up();
  end
endmodule